// File: doc/BRIEF.md
# DMA Descriptor Loader

This block prepares a DMA channel for its next work unit. A one-cycle `kick` starts it; the kick comes either when software starts the channel or when the previous work unit ends. On an accepted kick the block latches the programmed channel parameters. It then decodes the configuration word, which gives the element size, the flow mode and the descriptor length. It checks the stride and alignment rules and the descriptor-length rules for the chosen mode.

When the mode needs it, the block reads 16-bit descriptor words from memory, one at a time, through a request/valid read port. Each word goes into a parameter register chosen by the mode and the word's position.

When loading completes, the block sets up the working state:

- the current descriptor pointer and the current address;
- the X and Y working counts, where a zero count becomes all ones.

It then pulses `done` and raises `running`. A configuration that breaks the rules raises `err`, performs no reads and leaves the channel not running. Address stepping during the transfer and data movement belong to other blocks.

Top module: `dma_desc_loader`

## Requirements
- R1: Configuration bits [1:0] select the element size: 2'b10 gives 4 bytes, 2'b01 gives 2 bytes, and any other value gives 1 byte. A programmed X modify equal to plus or minus that size is accepted.
- R2: An X modify whose magnitude differs from the element size is a configuration error: `err` goes to 1, `running` goes to 0, no read is issued and `done` does not pulse.
- R3: A start address that is not a multiple of the element size sets `err`. The load still completes with a `done` pulse. An aligned start address leaves `err` at 0.
- R4: Flow code (configuration bits [6:4]) 0 (stop) and 1 (auto-repeat) require a descriptor length (bits [11:8]) of zero. Such a load issues no reads.
- R5: Flow code 4 (array) requires a length of 1 to 7. Its words are read starting at the programmed current descriptor pointer and fill the parameter slots directly.
- R6: Flow code 6 (short chain) requires a length of 1 to 8. Its words are read starting at the next-descriptor pointer, and the first word replaces the low half of that pointer.
- R7: Flow code 7 (long chain) requires a length of 1 to 9. Its words are read starting at the next-descriptor pointer, and the first two words replace the pointer's low half and then its high half.
- R8: The descriptor words after any pointer words fill these slots in this order: start address low, start address high, configuration, X count, X modify, Y count, Y modify.
- R9: Word i is requested at fetch base + 2·i. `rd_req` is a one-cycle pulse. No new request is issued until `rd_valid` has returned the previous word. The number of requests equals the descriptor length.
- R10: On completion, `cur_desc` takes the next-descriptor pointer and `cur_addr` takes the start address. At the same time `done` pulses for one cycle and `running` becomes 1.
- R11: A loaded X or Y count of zero appears in `cur_xcnt` or `cur_ycnt` as 16'hFFFF. Any other count appears unchanged.
- R12: Flow codes 2, 3 and 5, and any descriptor length outside the range for its mode, are configuration errors with the same outcome as R2.
- R13: A kick while busy is ignored. An accepted kick clears `err`. While the block is idle, the working state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Start a load (channel start or work-unit end) |
| prog_cfg | input | 16 | Programmed configuration word |
| prog_next | input | 32 | Programmed next-descriptor pointer |
| prog_start | input | 32 | Programmed start address |
| prog_cur_desc | input | 32 | Programmed current descriptor pointer |
| prog_xcnt | input | 16 | Programmed X count |
| prog_xmod | input | 16 | Programmed X modify (signed) |
| prog_ycnt | input | 16 | Programmed Y count |
| prog_ymod | input | 16 | Programmed Y modify (signed) |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle load-complete strobe |
| err | output | 1 | Error flag |
| running | output | 1 | Channel running |
| next_ptr | output | 32 | Next-descriptor pointer register |
| start_addr | output | 32 | Start address register |
| prm_cfg | output | 16 | Configuration register |
| prm_xcnt | output | 16 | X count register |
| prm_xmod | output | 16 | X modify register |
| prm_ycnt | output | 16 | Y count register |
| prm_ymod | output | 16 | Y modify register |
| cur_desc | output | 32 | Current descriptor pointer |
| cur_addr | output | 32 | Current address |
| cur_xcnt | output | 16 | Current X count |
| cur_ycnt | output | 16 | Current Y count |

## Verification
The assertions check the read handshake on every cycle: single-cycle requests and at most one word outstanding. They also check the completion state: done is a single pulse, running is set, the working address and pointer match the loaded registers, and the working counts are never zero. They further check that an aborted load ends with err set and running clear, and that an accepted kick clears the error flag.

Only the bench's sweeps can show the rest:

- which flow and length combinations count as legal;
- where each fetched word lands and which base address each mode reads from;
- the element-size, stride and alignment decisions;
- that the arithmetic model gives the expected register contents.

// File: rtl/ddl_pkg.sv
package ddl_pkg;

  localparam int WS_LSB   = 0;
  localparam int FLOW_LSB = 4;
  localparam int NDS_LSB  = 8;
  localparam int NSLOT    = 9;

  localparam logic [2:0] FLOW_STOP  = 3'd0;
  localparam logic [2:0] FLOW_AUTO  = 3'd1;
  localparam logic [2:0] FLOW_ARRAY = 3'd4;
  localparam logic [2:0] FLOW_SMALL = 3'd6;
  localparam logic [2:0] FLOW_LARGE = 3'd7;

  typedef enum logic [3:0] {
    SLOT_NLO  = 4'd0,
    SLOT_NHI  = 4'd1,
    SLOT_SLO  = 4'd2,
    SLOT_SHI  = 4'd3,
    SLOT_CFG  = 4'd4,
    SLOT_XCNT = 4'd5,
    SLOT_XMOD = 4'd6,
    SLOT_YCNT = 4'd7,
    SLOT_YMOD = 4'd8
  } slot_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_REQ    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_FINISH = 3'd4
  } state_e;

  // Largest legal descriptor length for each chained mode.
  function automatic logic [3:0] max_words(input logic [2:0] flow);
    case (flow)
      FLOW_ARRAY: max_words = 4'd7;
      FLOW_SMALL: max_words = 4'd8;
      FLOW_LARGE: max_words = 4'd9;
      default:    max_words = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddl_decode.sv
module ddl_decode import ddl_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2 * WORD_W,
  parameter int NDS_W  = 4
) (
  input  logic [WORD_W-1:0] cfg,
  input  logic [WORD_W-1:0] xmod,
  input  logic [1:0]        start_lsb,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic [ADDR_W-1:0] cur_desc,
  output logic [2:0]        flow,
  output logic [NDS_W-1:0]  nwords,
  output logic              cfg_bad,
  output logic              misaligned,
  output logic [ADDR_W-1:0] fetch_base
);

  logic [1:0]        ws;
  logic [2:0]        esize;
  logic [WORD_W-1:0] esz_w;
  logic [1:0]        amask;
  logic              stride_ok;
  logic              size_ok;

  always_comb begin
    ws     = cfg[WS_LSB +: 2];
    flow   = cfg[FLOW_LSB +: 3];
    nwords = cfg[NDS_LSB +: NDS_W];

    case (ws)
      2'b10:   esize = 3'd4;
      2'b01:   esize = 3'd2;
      default: esize = 3'd1;
    endcase

    esz_w     = WORD_W'(esize);
    stride_ok = (xmod == esz_w) || (xmod == (WORD_W'(0) - esz_w));

    if ((flow == FLOW_STOP) || (flow == FLOW_AUTO))
      size_ok = (nwords == '0);
    else if ((flow == FLOW_ARRAY) || (flow == FLOW_SMALL) || (flow == FLOW_LARGE))
      size_ok = (nwords != '0) && (nwords <= NDS_W'(max_words(flow)));
    else
      size_ok = 1'b0;

    cfg_bad    = !size_ok || !stride_ok;
    amask      = 2'(esize - 3'd1);
    misaligned = |(start_lsb & amask);
    fetch_base = ((flow == FLOW_SMALL) || (flow == FLOW_LARGE)) ? next_ptr : cur_desc;
  end

endmodule

// File: rtl/ddl_slot_map.sv
module ddl_slot_map import ddl_pkg::*; #(
  parameter int NDS_W = 4
) (
  input  logic [2:0]       flow,
  input  logic [NDS_W-1:0] idx,
  output slot_e            slot
);

  logic [3:0] idx4;

  always_comb begin
    idx4 = 4'(idx);
    case (flow)
      FLOW_LARGE: slot = slot_e'(idx4);
      FLOW_SMALL: slot = (idx4 == 4'd0) ? SLOT_NLO : slot_e'(idx4 + 4'd1);
      default:    slot = slot_e'(idx4 + 4'd2);
    endcase
  end

endmodule

// File: rtl/ddl_seq.sv
module ddl_seq import ddl_pkg::*; #(
  parameter int NDS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             cfg_bad,
  input  logic [NDS_W-1:0] nwords_in,
  input  logic [2:0]       flow_in,
  input  logic             rd_valid,
  output logic             accept,
  output logic             check,
  output logic             abort,
  output logic             rd_req,
  output logic             store,
  output logic             finish,
  output logic             busy,
  output logic [NDS_W-1:0] idx,
  output logic [2:0]       flow_q
);

  state_e           state_q, state_d;
  logic [NDS_W-1:0] idx_q, idx_d;
  logic [NDS_W-1:0] n_q;
  logic             last;

  always_comb begin
    accept = (state_q == ST_IDLE) && kick;
    check  = (state_q == ST_DECODE);
    abort  = check && cfg_bad;
    rd_req = (state_q == ST_REQ);
    store  = (state_q == ST_WAIT) && rd_valid;
    finish = (state_q == ST_FINISH);
    busy   = (state_q != ST_IDLE);
    last   = (idx_q == n_q - 1'b1);

    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (kick) state_d = ST_DECODE;
      ST_DECODE: begin
        if (cfg_bad)               state_d = ST_IDLE;
        else if (nwords_in == '0)  state_d = ST_FINISH;
        else                       state_d = ST_REQ;
      end
      ST_REQ:    state_d = ST_WAIT;
      ST_WAIT:   if (rd_valid) state_d = last ? ST_FINISH : ST_REQ;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase

    idx_d = idx_q;
    if (accept)     idx_d = '0;
    else if (store) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      n_q     <= '0;
      flow_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (check) begin
        n_q    <= nwords_in;
        flow_q <= flow_in;
      end
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader import ddl_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2 * WORD_W,
  parameter int NDS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [WORD_W-1:0] prog_cfg,
  input  logic [ADDR_W-1:0] prog_next,
  input  logic [ADDR_W-1:0] prog_start,
  input  logic [ADDR_W-1:0] prog_cur_desc,
  input  logic [WORD_W-1:0] prog_xcnt,
  input  logic [WORD_W-1:0] prog_xmod,
  input  logic [WORD_W-1:0] prog_ycnt,
  input  logic [WORD_W-1:0] prog_ymod,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              running,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] start_addr,
  output logic [WORD_W-1:0] prm_cfg,
  output logic [WORD_W-1:0] prm_xcnt,
  output logic [WORD_W-1:0] prm_xmod,
  output logic [WORD_W-1:0] prm_ycnt,
  output logic [WORD_W-1:0] prm_ymod,
  output logic [ADDR_W-1:0] cur_desc,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_xcnt,
  output logic [WORD_W-1:0] cur_ycnt
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);
  localparam logic [WORD_W-1:0] CNT_FULL   = '1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic             accept, check, abort, store, finish;
  logic [NDS_W-1:0] idx;
  logic [2:0]       flow_q, flow_dec;
  logic [NDS_W-1:0] nwords;
  logic             cfg_bad, misaligned;
  logic [ADDR_W-1:0] fetch_base;
  slot_e            slot;

  logic [WORD_W-1:0] prog_w [NSLOT];
  logic [WORD_W-1:0] prm    [NSLOT];

  always_comb begin
    prog_w[SLOT_NLO]  = prog_next[WORD_W-1:0];
    prog_w[SLOT_NHI]  = prog_next[ADDR_W-1:WORD_W];
    prog_w[SLOT_SLO]  = prog_start[WORD_W-1:0];
    prog_w[SLOT_SHI]  = prog_start[ADDR_W-1:WORD_W];
    prog_w[SLOT_CFG]  = prog_cfg;
    prog_w[SLOT_XCNT] = prog_xcnt;
    prog_w[SLOT_XMOD] = prog_xmod;
    prog_w[SLOT_YCNT] = prog_ycnt;
    prog_w[SLOT_YMOD] = prog_ymod;
  end

  // Parameter slots: programmed on accept, overwritten by fetched words.
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [WORD_W-1:0] q, d;
    logic              en;
    always_comb begin
      en = accept || (store && (slot == slot_e'(k)));
      d  = accept ? prog_w[k] : rd_data;
    end
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) q <= '0;
      else if (en)     q <= d;
    end
    assign prm[k] = q;
  end

  assign next_ptr   = {prm[SLOT_NHI], prm[SLOT_NLO]};
  assign start_addr = {prm[SLOT_SHI], prm[SLOT_SLO]};
  assign prm_cfg    = prm[SLOT_CFG];
  assign prm_xcnt   = prm[SLOT_XCNT];
  assign prm_xmod   = prm[SLOT_XMOD];
  assign prm_ycnt   = prm[SLOT_YCNT];
  assign prm_ymod   = prm[SLOT_YMOD];

  ddl_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NDS_W(NDS_W)) i_decode (
    .cfg        (prm_cfg),
    .xmod       (prm_xmod),
    .start_lsb  (start_addr[1:0]),
    .next_ptr   (next_ptr),
    .cur_desc   (cur_desc),
    .flow       (flow_dec),
    .nwords     (nwords),
    .cfg_bad    (cfg_bad),
    .misaligned (misaligned),
    .fetch_base (fetch_base)
  );

  ddl_seq #(.NDS_W(NDS_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .kick      (kick),
    .cfg_bad   (cfg_bad),
    .nwords_in (nwords),
    .flow_in   (flow_dec),
    .rd_valid  (rd_valid),
    .accept    (accept),
    .check     (check),
    .abort     (abort),
    .rd_req    (rd_req),
    .store     (store),
    .finish    (finish),
    .busy      (busy),
    .idx       (idx),
    .flow_q    (flow_q)
  );

  ddl_slot_map #(.NDS_W(NDS_W)) i_slot_map (
    .flow (flow_q),
    .idx  (idx),
    .slot (slot)
  );

  // Working state and flags: next-state logic.
  logic [ADDR_W-1:0] fetch_q, fetch_d;
  logic [ADDR_W-1:0] cdesc_q, cdesc_d;
  logic [ADDR_W-1:0] caddr_q;
  logic [WORD_W-1:0] cx_q, cy_q, cx_d, cy_d;
  logic              err_q, err_d, run_q, run_d, done_q;

  always_comb begin
    fetch_d = fetch_q;
    if (check)      fetch_d = fetch_base;
    else if (store) fetch_d = fetch_q + WORD_BYTES;

    cdesc_d = cdesc_q;
    if (accept)      cdesc_d = prog_cur_desc;
    else if (finish) cdesc_d = next_ptr;

    cx_d = (prm_xcnt == '0) ? CNT_FULL : prm_xcnt;
    cy_d = (prm_ycnt == '0) ? CNT_FULL : prm_ycnt;

    err_d = err_q;
    if (accept)                             err_d = 1'b0;
    else if (check && (cfg_bad || misaligned)) err_d = 1'b1;

    run_d = run_q;
    if (abort)       run_d = 1'b0;
    else if (finish) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      fetch_q <= '0;
      cdesc_q <= '0;
      caddr_q <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
      err_q   <= 1'b0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      fetch_q <= fetch_d;
      cdesc_q <= cdesc_d;
      err_q   <= err_d;
      run_q   <= run_d;
      done_q  <= finish;
      if (finish) begin
        caddr_q <= start_addr;
        cx_q    <= cx_d;
        cy_q    <= cy_d;
      end
    end
  end

  assign rd_addr  = fetch_q;
  assign cur_desc = cdesc_q;
  assign cur_addr = caddr_q;
  assign cur_xcnt = cx_q;
  assign cur_ycnt = cy_q;
  assign err      = err_q;
  assign running  = run_q;
  assign done     = done_q;

endmodule

// File: rtl/ddl_checker.sv
module ddl_checker #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kick,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              running,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] next_ptr,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] cur_desc,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [WORD_W-1:0] cur_xcnt,
  input logic [WORD_W-1:0] cur_ycnt
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (rd_req)   pend_q <= 1'b1;
    else if (rd_valid) pend_q <= 1'b0;
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R9
  AST_REQ_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !pend_q); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (running && (cur_addr == start_addr) && (cur_desc == next_ptr))); // R10
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cur_xcnt != '0) && (cur_ycnt != '0))); // R11
  AST_ABORT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !done) |-> (err && !running)); // R12
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err); // R13
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !kick) |=> $stable(cur_addr)); // R13

endmodule

bind dma_desc_loader ddl_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_ddl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .kick       (kick),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .running    (running),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .next_ptr   (next_ptr),
  .start_addr (start_addr),
  .cur_desc   (cur_desc),
  .cur_addr   (cur_addr),
  .cur_xcnt   (cur_xcnt),
  .cur_ycnt   (cur_ycnt)
);

// File: tb/test_dma_desc_loader.sv
`timescale 1ns/1ps
module test_dma_desc_loader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        kick;
  logic [15:0] prog_cfg, prog_xcnt, prog_xmod, prog_ycnt, prog_ymod;
  logic [31:0] prog_next, prog_start, prog_cur_desc;
  logic        rd_req, rd_valid;
  logic [31:0] rd_addr;
  logic [15:0] rd_data;
  logic        busy, done, err, running;
  logic [31:0] next_ptr, start_addr, cur_desc, cur_addr;
  logic [15:0] prm_cfg, prm_xcnt, prm_xmod, prm_ycnt, prm_ymod, cur_xcnt, cur_ycnt;

  int checks = 0;
  int fails  = 0;
  int n_reads = 0;
  logic [31:0] rd_log [16];

  always #2.5 clk = ~clk;

  dma_desc_loader i_dma_desc_loader (
    .clk(clk), .rst_n(rst_n), .kick(kick),
    .prog_cfg(prog_cfg), .prog_next(prog_next), .prog_start(prog_start),
    .prog_cur_desc(prog_cur_desc), .prog_xcnt(prog_xcnt), .prog_xmod(prog_xmod),
    .prog_ycnt(prog_ycnt), .prog_ymod(prog_ymod),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err), .running(running),
    .next_ptr(next_ptr), .start_addr(start_addr), .prm_cfg(prm_cfg),
    .prm_xcnt(prm_xcnt), .prm_xmod(prm_xmod), .prm_ycnt(prm_ycnt), .prm_ymod(prm_ymod),
    .cur_desc(cur_desc), .cur_addr(cur_addr), .cur_xcnt(cur_xcnt), .cur_ycnt(cur_ycnt)
  );

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[16:1] ^ 16'h3C5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: one word per request, latency varies 1..3 cycles.
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      if (rd_req === 1'b1) begin
        logic [31:0] a;
        a = rd_addr;
        if (n_reads < 16) rd_log[n_reads] = a;
        n_reads++;
        repeat (1 + (n_reads % 3)) @(negedge clk);
        rd_data  = memf(a);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic run(input logic [15:0] cfg, input logic [31:0] nxt, input logic [31:0] st,
                     input logic [31:0] cur, input logic [15:0] xc, input logic [15:0] xm,
                     input logic [15:0] yc, input logic [15:0] ym, input bit inject);
    logic [15:0] e [9];
    logic [31:0] prev_addr, base;
    logic [15:0] prev_x, prev_y;
    int esz, fl, nd, guard;
    bit legal, stride_ok, misal, saw_done;
    string tag;

    esz = (cfg[1:0] == 2'b10) ? 4 : (cfg[1:0] == 2'b01) ? 2 : 1;
    fl  = int'(cfg[6:4]);
    nd  = int'(cfg[11:8]);
    if (fl == 0 || fl == 1) legal = (nd == 0);
    else if (fl == 4)       legal = (nd >= 1 && nd <= 7);
    else if (fl == 6)       legal = (nd >= 1 && nd <= 8);
    else if (fl == 7)       legal = (nd >= 1 && nd <= 9);
    else                    legal = 0;
    stride_ok = (xm == 16'(esz)) || (xm == 16'(0 - esz));
    misal     = (int'(st[1:0]) % esz) != 0;
    tag = (fl == 4) ? "R5" : (fl == 6) ? "R6" : (fl == 7) ? "R7" : (legal ? "R4" : "R12");

    e[0] = nxt[15:0]; e[1] = nxt[31:16]; e[2] = st[15:0]; e[3] = st[31:16];
    e[4] = cfg; e[5] = xc; e[6] = xm; e[7] = yc; e[8] = ym;
    prev_addr = cur_addr; prev_x = cur_xcnt; prev_y = cur_ycnt;

    @(negedge clk);
    prog_cfg = cfg; prog_next = nxt; prog_start = st; prog_cur_desc = cur;
    prog_xcnt = xc; prog_xmod = xm; prog_ycnt = yc; prog_ymod = ym;
    n_reads = 0;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    saw_done = 0;
    guard = 0;
    while (busy === 1'b1 && guard < 400) begin
      if (done === 1'b1) saw_done = 1;
      if (inject && guard == 3) begin kick = 1'b1; prog_cfg = 16'h0000; prog_next = 32'hDEAD0000; end
      if (inject && guard == 4) kick = 1'b0;
      @(negedge clk);
      guard++;
    end
    if (done === 1'b1) saw_done = 1;
    chk("R9 hang", 32'(guard < 400), 32'd1);

    if (!(legal && stride_ok)) begin
      chk(stride_ok ? "R12 err" : "R2 err", 32'(err), 32'd1);
      chk(stride_ok ? "R12 done" : "R2 done", 32'(saw_done), 32'd0);
      chk(stride_ok ? "R12 running" : "R2 running", 32'(running), 32'd0);
      chk(stride_ok ? "R12 reads" : "R2 reads", 32'(n_reads), 32'd0);
      chk("R12 cur_addr", cur_addr, prev_addr);
      chk("R12 cur_x", 32'(cur_xcnt), 32'(prev_x));
      chk("R12 cur_y", 32'(cur_ycnt), 32'(prev_y));
      chk("R12 regs", {prm_cfg, prm_xcnt}, {e[4], e[5]});
    end else begin
      base = (fl >= 6) ? nxt : cur;
      for (int i = 0; i < nd; i++) begin
        int s;
        if (fl == 7)      s = i;
        else if (fl == 6) s = (i == 0) ? 0 : i + 1;
        else              s = i + 2;
        e[s] = memf(base + 32'(2 * i));
      end
      chk(tag, 32'(n_reads), 32'(nd));
      for (int i = 0; i < nd && i < 16; i++)
        chk("R9 addr", rd_log[i], base + 32'(2 * i));
      chk("R10 done", 32'(saw_done), 32'd1);
      chk("R10 running", 32'(running), 32'd1);
      chk(misal ? "R3 err set" : "R3 err clear", 32'(err), 32'(misal));
      chk(tag, next_ptr, {e[1], e[0]});
      chk("R8 start", start_addr, {e[3], e[2]});
      chk("R8 cfg", 32'(prm_cfg), 32'(e[4]));
      chk("R8 xcnt/xmod", {prm_xcnt, prm_xmod}, {e[5], e[6]});
      chk("R8 ycnt/ymod", {prm_ycnt, prm_ymod}, {e[7], e[8]});
      chk("R10 cur_desc", cur_desc, {e[1], e[0]});
      chk("R10 cur_addr", cur_addr, {e[3], e[2]});
      chk("R11 cur_x", 32'(cur_xcnt), (e[5] == 16'h0) ? 32'h0000FFFF : 32'(e[5]));
      chk("R11 cur_y", 32'(cur_ycnt), (e[7] == 16'h0) ? 32'h0000FFFF : 32'(e[7]));
    end
  endtask

  task automatic finish_bench();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL WATCHDOG actual=running expected=finished");
    finish_bench();
  end

  initial begin
    rst_n = 1'b0; kick = 1'b0;
    prog_cfg = '0; prog_next = '0; prog_start = '0; prog_cur_desc = '0;
    prog_xcnt = '0; prog_xmod = '0; prog_ycnt = '0; prog_ymod = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state (R13: idle holds)
    chk("R13 reset busy", 32'(busy), 32'd0);
    chk("R13 reset flags", {29'd0, done, err, running}, 32'd0);
    chk("R9 reset rd_req", 32'(rd_req), 32'd0);
    chk("R10 reset cur_addr", cur_addr, 32'd0);

    // Sweep every flow code and descriptor length, 16-bit elements.
    for (int fl = 0; fl < 8; fl++) begin
      for (int nd = 0; nd < 16; nd++) begin
        run(16'((nd << 8) | (fl << 4) | 1), 32'h1000_0000 + 32'(fl * 256),
            32'h3000_0000 + 32'(nd * 4), 32'h2000_0000 + 32'(nd * 64),
            16'h0010 + 16'(fl), 16'h0002, 16'h0003 + 16'(nd), 16'hFFF0, 1'b0);
      end
    end

    // Element size, stride and alignment sweep (R1, R2, R3), stop mode.
    for (int ws = 0; ws < 4; ws++) begin
      for (int m = 0; m < 7; m++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic [15:0] xm;
          int esz;
          esz = (ws == 2) ? 4 : (ws == 1) ? 2 : 1;
          case (m)
            0: xm = 16'd1;  1: xm = 16'hFFFF; 2: xm = 16'd2; 3: xm = 16'hFFFE;
            4: xm = 16'd4;  5: xm = 16'hFFFC; default: xm = 16'd3;
          endcase
          run(16'(ws), 32'h4000_0000, 32'h5000_0000 + 32'(lo), 32'h6000_0000,
              16'h0020, xm, 16'h0004, 16'h0000, 1'b0);
          if (xm == 16'(esz) || xm == 16'(0 - esz))
            chk("R1 size accepted", 32'(running), 32'd1);
          else
            chk("R2 stride rejected", 32'(running), 32'd0);
        end
      end
    end

    // Zero counts: programmed (stop mode) and fetched (long chain, X count word is zero).
    run(16'h0001, 32'h0000_1000, 32'h0000_2000, 32'h0, 16'h0000, 16'h0002, 16'h0000, 16'h0, 1'b0);
    chk("R11 programmed zero x", 32'(cur_xcnt), 32'h0000FFFF);
    chk("R11 programmed zero y", 32'(cur_ycnt), 32'h0000FFFF);
    run(16'h0971, 32'h0000_78AA, 32'h0, 32'h0, 16'h0005, 16'h0002, 16'h0006, 16'h0, 1'b0);
    chk("R11 fetched zero x", 32'(cur_xcnt), 32'h0000FFFF);

    // Kick while busy is ignored; error cleared by the next accepted kick.
    run(16'h0971, 32'h0000_9000, 32'h0, 32'h0, 16'h0005, 16'h0002, 16'h0006, 16'h0, 1'b1);
    chk("R13 busy kick ignored", 32'(n_reads), 32'd9);
    run(16'h0021, 32'h0, 32'h0, 32'h0, 16'h1, 16'h2, 16'h1, 16'h0, 1'b0);
    chk("R13 err after bad", 32'(err), 32'd1);
    run(16'h0001, 32'h0, 32'h0, 32'h0, 16'h1, 16'h2, 16'h1, 16'h0, 1'b0);
    chk("R13 err cleared", 32'(err), 32'd0);

    finish_bench();
  end

endmodule